// File: doc/BRIEF.md
# Register-Bus Serial Port with Interrupts

This block is a small serial port that sits on a 32-bit register bus. Software writes a byte into a one-byte transmit holding buffer; a bit-timed shifter moves it onto the serial output as a start bit, eight data bits (least significant first) and a stop bit. A matching receiver watches the serial input, finds a start bit by its falling edge, samples each bit at its middle and places the byte into a one-byte receive holding buffer. The bit period is a raw count of system clocks per bit, held in a divider register that refuses values below a floor of 16.

The byte stream in each direction crosses the bus, so flow control is done with the two buffer-full flags. The transmit-full flag is the "not ready" indication: software may hand over a new byte only while it reads as zero, and the shifter draws the byte out of the buffer in the cycle it starts a frame. The receive-full flag is the "valid" indication: software collects the byte while it is set, and the read itself clears it. The receiver has no back-pressure: a byte that lands on an uncollected one replaces it.

Each direction has its own enable and interrupt enable. A sticky interrupt flag per direction drives its own output, and both are ORed onto a combined output. The flags are read at one offset and cleared by writing ones to the same offset.

Top module: `sbus_serial_port`

## Requirements
- R1: After reset the serial output is high, all three interrupt outputs are low, the control, status and interrupt registers read zero and the divider reads 16.
- R2: Registers are addressed by byte address with word alignment: data 0x00, status 0x04, control 0x08, interrupt 0x0C, divider 0x10. Control bits 0..3 (transmit enable, receive enable, transmit interrupt enable, receive interrupt enable) read back with upper bits zero; status and interrupt registers return zero above bit 1; an unmapped offset reads zero.
- R3: A divider write below 16 is ignored and the old value is kept; a write of 16 or more is stored and read back.
- R4: With transmit enabled, a byte written to data bits 7..0 is sent as one low start bit, eight data bits LSB first and one high stop bit, each lasting divider clocks; status bit 0 (transmit buffer full) clears when the shifter takes the byte, and a second byte written while a frame is in flight keeps bit 0 set until that frame ends.
- R5: With transmit disabled, a written byte stays in the buffer, status bit 0 stays 1 and the serial output stays high; enabling transmit then sends it.
- R6: With receive enabled, a valid frame on the serial input sets status bit 1 (receive buffer full); reading data returns the byte in bits 7..0 with upper bits zero and clears status bit 1.
- R7: A low pulse on the serial input that is high again at half the divider after its falling edge is discarded and delivers no byte.
- R8: A byte that arrives while status bit 1 is set overwrites the stored byte.
- R9: With receive disabled, a frame on the serial input delivers no byte.
- R10: With the transmit interrupt enabled, the shifter taking a byte sets interrupt bit 0 and raises the transmit interrupt output; it stays set until a write of 1 to interrupt bit 0.
- R11: With the receive interrupt enabled, a received byte sets interrupt bit 1 and raises the receive interrupt output; writing 3 to the interrupt offset clears both flags; the combined output is high whenever either flag is set.
- R12: With an interrupt enable clear, the matching event leaves its flag clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Bus access in this cycle |
| bus_wr | input | 1 | 1 for write, 0 for read |
| bus_addr | input | ADDR_W (5) | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the access cycle |
| txd | output | 1 | Serial output, idles high |
| rxd | input | 1 | Serial input |
| irq_tx | output | 1 | Transmit interrupt flag |
| irq_rx | output | 1 | Receive interrupt flag |
| irq_any | output | 1 | OR of both interrupt flags |

## Verification
A wrong buffer-full flag shows on the status read at once and, for the transmit side, as a frame that starts too early, never starts or repeats, which the serial-line scoreboard sees within one frame time. A wrong bit counter or divider reload shows as a misplaced stop bit or a shifted data bit within the first frame, since the scoreboard samples every bit at its middle. A receiver that does not reject a short start pulse or does not honour its enable leaves a stray byte in the receive buffer, seen at the next status read; stuck or unclearable interrupt flags show on the interrupt pins in the cycle after the clearing write.

// File: rtl/sbus_serial_pkg.sv
package sbus_serial_pkg;
  // Word index of each register (byte address bits above the word offset).
  localparam int WIX_DATA   = 0;
  localparam int WIX_STATUS = 1;
  localparam int WIX_CTRL   = 2;
  localparam int WIX_IRQ    = 3;
  localparam int WIX_DIV    = 4;

  // Control bit positions.
  localparam int CB_TX_EN = 0;
  localparam int CB_RX_EN = 1;
  localparam int CB_TX_IE = 2;
  localparam int CB_RX_IE = 3;
  localparam int CTRL_W   = 4;

  // Status / interrupt bit positions.
  localparam int SB_TX = 0;
  localparam int SB_RX = 1;

  localparam int BYTE_W = 8;

  typedef enum logic [1:0] {
    RXS_IDLE  = 2'd0,
    RXS_START = 2'd1,
    RXS_DATA  = 2'd2,
    RXS_STOP  = 2'd3
  } rx_state_e;
endpackage

// File: rtl/sbus_serial_tx.sv
module sbus_serial_tx
  import sbus_serial_pkg::*;
#(
  parameter int DIV_W = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic [DIV_W-1:0]  div,
  input  logic              have_byte,
  input  logic [BYTE_W-1:0] byte_in,
  output logic              take,
  output logic              busy,
  output logic              txd
);
  localparam int FRAME_W = BYTE_W + 2;
  localparam int BITN_W  = $clog2(FRAME_W);
  localparam logic [BITN_W-1:0] LAST_BIT = BITN_W'(FRAME_W - 1);

  logic [FRAME_W-1:0] shreg_q;
  logic [DIV_W-1:0]   cnt_q;
  logic [BITN_W-1:0]  bitn_q;
  logic               busy_q;
  logic               txd_q;

  assign take = !busy_q && enable && have_byte;
  assign busy = busy_q;
  assign txd  = txd_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg_q <= '1;
      cnt_q   <= '0;
      bitn_q  <= '0;
      busy_q  <= 1'b0;
      txd_q   <= 1'b1;
    end else if (take) begin
      shreg_q <= {1'b1, byte_in, 1'b0};
      cnt_q   <= div - DIV_W'(1);
      bitn_q  <= '0;
      busy_q  <= 1'b1;
      txd_q   <= 1'b0;
    end else if (busy_q) begin
      if (cnt_q == '0) begin
        if (bitn_q == LAST_BIT) begin
          busy_q <= 1'b0;
          txd_q  <= 1'b1;
        end else begin
          bitn_q  <= bitn_q + BITN_W'(1);
          cnt_q   <= div - DIV_W'(1);
          txd_q   <= shreg_q[1];
          shreg_q <= {1'b1, shreg_q[FRAME_W-1:1]};
        end
      end else begin
        cnt_q <= cnt_q - DIV_W'(1);
      end
    end
  end
endmodule

// File: rtl/sbus_serial_rx.sv
module sbus_serial_rx
  import sbus_serial_pkg::*;
#(
  parameter int DIV_W = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic [DIV_W-1:0]  div,
  input  logic              rxd,
  output logic              done,
  output logic [BYTE_W-1:0] data
);
  localparam int BITN_W = $clog2(BYTE_W);
  localparam logic [BITN_W-1:0] LAST_DATA = BITN_W'(BYTE_W - 1);

  logic              sync1_q, sync2_q, prev_q;
  logic              fall;
  rx_state_e         state_q;
  logic [DIV_W-1:0]  cnt_q;
  logic [BITN_W-1:0] bitn_q;
  logic [BYTE_W-1:0] shreg_q;
  logic              done_q;
  logic [BYTE_W-1:0] data_q;

  assign fall = prev_q && !sync2_q;
  assign done = done_q;
  assign data = data_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1_q <= 1'b1;
      sync2_q <= 1'b1;
      prev_q  <= 1'b1;
    end else begin
      sync1_q <= rxd;
      sync2_q <= sync1_q;
      prev_q  <= sync2_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= RXS_IDLE;
      cnt_q   <= '0;
      bitn_q  <= '0;
      shreg_q <= '0;
      done_q  <= 1'b0;
      data_q  <= '0;
    end else begin
      done_q <= 1'b0;
      if (!enable) begin
        state_q <= RXS_IDLE;
      end else begin
        unique case (state_q)
          RXS_IDLE: begin
            if (fall) begin
              state_q <= RXS_START;
              cnt_q   <= (div >> 1) - DIV_W'(1);
            end
          end
          RXS_START: begin
            if (cnt_q == '0) begin
              if (!sync2_q) begin
                state_q <= RXS_DATA;
                cnt_q   <= div - DIV_W'(1);
                bitn_q  <= '0;
              end else begin
                state_q <= RXS_IDLE;
              end
            end else begin
              cnt_q <= cnt_q - DIV_W'(1);
            end
          end
          RXS_DATA: begin
            if (cnt_q == '0) begin
              shreg_q <= {sync2_q, shreg_q[BYTE_W-1:1]};
              cnt_q   <= div - DIV_W'(1);
              if (bitn_q == LAST_DATA) state_q <= RXS_STOP;
              else bitn_q <= bitn_q + BITN_W'(1);
            end else begin
              cnt_q <= cnt_q - DIV_W'(1);
            end
          end
          RXS_STOP: begin
            if (cnt_q == '0) begin
              done_q  <= 1'b1;
              data_q  <= shreg_q;
              state_q <= RXS_IDLE;
            end else begin
              cnt_q <= cnt_q - DIV_W'(1);
            end
          end
          default: state_q <= RXS_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/sbus_serial_regs.sv
module sbus_serial_regs
  import sbus_serial_pkg::*;
#(
  parameter int ADDR_W  = 5,
  parameter int DIV_W   = 20,
  parameter int DIV_MIN = 16,
  parameter int DIV_RST = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic              tx_take,
  output logic              tx_full,
  output logic [BYTE_W-1:0] tx_byte,
  input  logic              rx_done,
  input  logic [BYTE_W-1:0] rx_byte,
  output logic              rx_full,
  output logic              tx_en,
  output logic              rx_en,
  output logic [DIV_W-1:0]  div,
  output logic              irq_tx,
  output logic              irq_rx
);
  localparam int WORD_W = ADDR_W - 2;
  localparam logic [WORD_W-1:0] W_DATA   = WORD_W'(WIX_DATA);
  localparam logic [WORD_W-1:0] W_STATUS = WORD_W'(WIX_STATUS);
  localparam logic [WORD_W-1:0] W_CTRL   = WORD_W'(WIX_CTRL);
  localparam logic [WORD_W-1:0] W_IRQ    = WORD_W'(WIX_IRQ);
  localparam logic [WORD_W-1:0] W_DIV    = WORD_W'(WIX_DIV);
  localparam logic [DIV_W-1:0]  DIV_INIT = DIV_W'(DIV_RST);

  logic [WORD_W-1:0] word;
  logic              aligned;
  logic              wr_data, wr_ctrl, wr_irq, wr_div, rd_data;
  logic              div_ok;

  logic [CTRL_W-1:0] ctrl_q;
  logic [DIV_W-1:0]  div_q;
  logic              tx_full_q, rx_full_q, irq_tx_q, irq_rx_q;
  logic [BYTE_W-1:0] tx_buf_q, rx_buf_q;

  assign word    = bus_addr[ADDR_W-1:2];
  assign aligned = (bus_addr[1:0] == 2'b00);
  assign wr_data = bus_sel &&  bus_wr && aligned && (word == W_DATA);
  assign wr_ctrl = bus_sel &&  bus_wr && aligned && (word == W_CTRL);
  assign wr_irq  = bus_sel &&  bus_wr && aligned && (word == W_IRQ);
  assign wr_div  = bus_sel &&  bus_wr && aligned && (word == W_DIV);
  assign rd_data = bus_sel && !bus_wr && aligned && (word == W_DATA);
  assign div_ok  = (bus_wdata >= 32'(DIV_MIN)) && ((bus_wdata >> DIV_W) == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q    <= '0;
      div_q     <= DIV_INIT;
      tx_full_q <= 1'b0;
      tx_buf_q  <= '0;
      rx_full_q <= 1'b0;
      rx_buf_q  <= '0;
      irq_tx_q  <= 1'b0;
      irq_rx_q  <= 1'b0;
    end else begin
      if (wr_ctrl) ctrl_q <= bus_wdata[CTRL_W-1:0];
      if (wr_div && div_ok) div_q <= bus_wdata[DIV_W-1:0];

      // Transmit holding buffer: a new write wins over the take.
      if (wr_data) begin
        tx_full_q <= 1'b1;
        tx_buf_q  <= bus_wdata[BYTE_W-1:0];
      end else if (tx_take) begin
        tx_full_q <= 1'b0;
      end

      // Receive holding buffer: an arriving byte wins over the read.
      if (rx_done) begin
        rx_full_q <= 1'b1;
        rx_buf_q  <= rx_byte;
      end else if (rd_data) begin
        rx_full_q <= 1'b0;
      end

      // Sticky flags: a setting event wins over a clearing write.
      if (tx_take && ctrl_q[CB_TX_IE]) irq_tx_q <= 1'b1;
      else if (wr_irq && bus_wdata[SB_TX]) irq_tx_q <= 1'b0;

      if (rx_done && ctrl_q[CB_RX_IE]) irq_rx_q <= 1'b1;
      else if (wr_irq && bus_wdata[SB_RX]) irq_rx_q <= 1'b0;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (aligned) begin
      unique case (word)
        W_DATA:   bus_rdata[BYTE_W-1:0] = rx_buf_q;
        W_STATUS: begin
          bus_rdata[SB_TX] = tx_full_q;
          bus_rdata[SB_RX] = rx_full_q;
        end
        W_CTRL:   bus_rdata[CTRL_W-1:0] = ctrl_q;
        W_IRQ:    begin
          bus_rdata[SB_TX] = irq_tx_q;
          bus_rdata[SB_RX] = irq_rx_q;
        end
        W_DIV:    bus_rdata[DIV_W-1:0] = div_q;
        default:  bus_rdata = '0;
      endcase
    end
  end

  assign tx_full = tx_full_q;
  assign tx_byte = tx_buf_q;
  assign rx_full = rx_full_q;
  assign tx_en   = ctrl_q[CB_TX_EN];
  assign rx_en   = ctrl_q[CB_RX_EN];
  assign div     = div_q;
  assign irq_tx  = irq_tx_q;
  assign irq_rx  = irq_rx_q;
endmodule

// File: rtl/sbus_serial_port.sv
module sbus_serial_port
  import sbus_serial_pkg::*;
#(
  parameter int ADDR_W  = 5,
  parameter int DIV_W   = 20,
  parameter int DIV_MIN = 16,
  parameter int DIV_RST = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              txd,
  input  logic              rxd,
  output logic              irq_tx,
  output logic              irq_rx,
  output logic              irq_any
);
  logic              tx_take, tx_full, tx_busy, tx_en;
  logic [BYTE_W-1:0] tx_byte;
  logic              rx_done, rx_full, rx_en;
  logic [BYTE_W-1:0] rx_byte;
  logic [DIV_W-1:0]  div_q;

  sbus_serial_regs #(
    .ADDR_W(ADDR_W), .DIV_W(DIV_W), .DIV_MIN(DIV_MIN), .DIV_RST(DIV_RST)
  ) u_regs (
    .clk(clk), .rst_n(rst_n),
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .tx_take(tx_take), .tx_full(tx_full), .tx_byte(tx_byte),
    .rx_done(rx_done), .rx_byte(rx_byte), .rx_full(rx_full),
    .tx_en(tx_en), .rx_en(rx_en), .div(div_q),
    .irq_tx(irq_tx), .irq_rx(irq_rx)
  );

  sbus_serial_tx #(.DIV_W(DIV_W)) u_tx (
    .clk(clk), .rst_n(rst_n), .enable(tx_en), .div(div_q),
    .have_byte(tx_full), .byte_in(tx_byte), .take(tx_take),
    .busy(tx_busy), .txd(txd)
  );

  sbus_serial_rx #(.DIV_W(DIV_W)) u_rx (
    .clk(clk), .rst_n(rst_n), .enable(rx_en), .div(div_q),
    .rxd(rxd), .done(rx_done), .data(rx_byte)
  );

  assign irq_any = irq_tx || irq_rx;
endmodule

// File: rtl/sbus_serial_chk.sv
module sbus_serial_chk #(
  parameter int ADDR_W  = 5,
  parameter int DIV_W   = 20,
  parameter int DIV_MIN = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_sel,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [31:0]       bus_wdata,
  input logic              txd,
  input logic              irq_tx,
  input logic              irq_rx,
  input logic              tx_take,
  input logic              tx_busy,
  input logic              rx_done,
  input logic              rx_full,
  input logic [DIV_W-1:0]  div_q
);
  logic clr_hit, rd_data_hit;
  assign clr_hit     = bus_sel && bus_wr && (bus_addr == ADDR_W'(12));
  assign rd_data_hit = bus_sel && !bus_wr && (bus_addr == ADDR_W'(0));

  // R3: the divider never drops below its floor
  a_r3_div_floor: assert property (@(posedge clk) disable iff (!rst_n)
    div_q >= DIV_W'(DIV_MIN));

  // R4: the line is high whenever no frame is in flight
  a_r4_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_busy |-> txd);

  // R6: a data read with no byte arriving empties the receive buffer
  a_r6_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data_hit && !rx_done) |=> !rx_full);

  // R10: the transmit flag holds until cleared
  a_r10_tx_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_tx && !(clr_hit && bus_wdata[0])) |=> irq_tx);

  // R10: writing one to bit 0 clears the transmit flag
  a_r10_tx_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_hit && bus_wdata[0] && !tx_take) |=> !irq_tx);

  // R11: writing one to bit 1 clears the receive flag
  a_r11_rx_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_hit && bus_wdata[1] && !rx_done) |=> !irq_rx);
endmodule

bind sbus_serial_port sbus_serial_chk #(
  .ADDR_W(ADDR_W), .DIV_W(DIV_W), .DIV_MIN(DIV_MIN)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .txd(txd),
  .irq_tx(irq_tx), .irq_rx(irq_rx), .tx_take(tx_take),
  .tx_busy(tx_busy), .rx_done(rx_done), .rx_full(rx_full),
  .div_q(div_q)
);

// File: tb/sbus_serial_port_tb.sv
module sbus_serial_port_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0;
  logic        bus_wr = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        txd;
  logic        rxd = 1'b1;
  logic        irq_tx, irq_rx, irq_any;

  int nchk = 0;
  int nfail = 0;
  int cur_div = 16;
  bit finished = 0;
  logic [7:0] exp_q[$];

  always #2 clk = ~clk;

  sbus_serial_port u_dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .txd(txd), .rxd(rxd), .irq_tx(irq_tx), .irq_rx(irq_rx),
    .irq_any(irq_any)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic bus_write(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_sel = 1'b0;
  endtask

  task automatic expect_reg(input logic [4:0] a, input logic [31:0] e,
                            input string req, input string what);
    logic [31:0] v;
    bus_read(a, v);
    check(v === e, req, what, v, e);
  endtask

  // Driver: push the expected byte, then hand it to the design.
  task automatic send_byte(input logic [7:0] b);
    exp_q.push_back(b);
    bus_write(5'h00, {24'h0, b});
  endtask

  task automatic rx_frame(input logic [7:0] b);
    @(negedge clk);
    rxd = 1'b0;
    repeat (cur_div) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      rxd = b[i];
      repeat (cur_div) @(negedge clk);
    end
    rxd = 1'b1;
    repeat (cur_div + 4) @(negedge clk);
  endtask

  task automatic drain_tx();
    wait (exp_q.size() == 0);
    repeat (cur_div * 2) @(negedge clk);
  endtask

  // Monitor: decode the serial output at mid-bit and compare with the queue.
  initial begin
    wait (rst_n);
    forever begin
      @(negedge clk);
      if (txd === 1'b0) begin
        logic [7:0] got;
        logic [7:0] exp;
        repeat (cur_div / 2 - 1) @(negedge clk);
        check(txd === 1'b0, "R4", "start bit low at mid-bit", {31'h0, txd}, 0);
        for (int i = 0; i < 8; i++) begin
          repeat (cur_div) @(negedge clk);
          got[i] = txd;
        end
        repeat (cur_div) @(negedge clk);
        check(txd === 1'b1, "R4", "stop bit high", {31'h0, txd}, 1);
        if (exp_q.size() == 0) begin
          check(1'b0, "R4", "frame with no byte queued", {24'h0, got}, 0);
        end else begin
          exp = exp_q.pop_front();
          check(got === exp, "R4", "transmitted byte", {24'h0, got}, {24'h0, exp});
        end
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      nchk++; nfail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R1: reset state
    check(txd === 1'b1, "R1", "txd after reset", {31'h0, txd}, 1);
    check(irq_any === 1'b0 && irq_tx === 1'b0 && irq_rx === 1'b0, "R1",
          "irq outputs after reset", {29'h0, irq_any, irq_tx, irq_rx}, 0);
    expect_reg(5'h04, 32'h0, "R1", "status after reset");
    expect_reg(5'h08, 32'h0, "R1", "control after reset");
    expect_reg(5'h0C, 32'h0, "R1", "irq after reset");
    expect_reg(5'h10, 32'd16, "R1", "divider after reset");

    // R2: register map and read-back widths
    bus_write(5'h08, 32'hFFFF_FFF0);
    expect_reg(5'h08, 32'h0, "R2", "control upper bits ignored");
    bus_write(5'h08, 32'h0000_000A);
    expect_reg(5'h08, 32'h0000_000A, "R2", "control readback");
    bus_write(5'h08, 32'h0);
    expect_reg(5'h14, 32'h0, "R2", "unmapped offset");
    bus_write(5'h10, 32'd40);
    expect_reg(5'h10, 32'd40, "R2", "divider readback");

    // R3: divider floor
    bus_write(5'h10, 32'd15);
    expect_reg(5'h10, 32'd40, "R3", "divider write of 15 ignored");
    bus_write(5'h10, 32'd16);
    expect_reg(5'h10, 32'd16, "R3", "divider write of 16 kept");
    cur_div = 16;

    // R5: transmitter disabled holds the byte
    bus_write(5'h08, 32'h2);
    send_byte(8'hA5);
    repeat (60) @(negedge clk);
    expect_reg(5'h04, 32'h1, "R5", "tx full held while disabled");
    check(txd === 1'b1, "R5", "txd idle while disabled", {31'h0, txd}, 1);
    bus_write(5'h08, 32'h3);
    repeat (4) @(negedge clk);
    expect_reg(5'h04, 32'h0, "R4", "tx full cleared on take");
    drain_tx();

    // R4: second byte waits behind a frame in flight
    send_byte(8'h3C);
    repeat (3) @(negedge clk);
    send_byte(8'h81);
    expect_reg(5'h04, 32'h1, "R4", "tx full while shifter busy");
    drain_tx();
    expect_reg(5'h04, 32'h0, "R4", "tx buffer empty after both frames");

    // R10: transmit interrupt
    bus_write(5'h08, 32'h7);
    send_byte(8'h55);
    repeat (4) @(negedge clk);
    check(irq_tx === 1'b1 && irq_any === 1'b1, "R10", "tx irq raised",
          {30'h0, irq_any, irq_tx}, 3);
    expect_reg(5'h0C, 32'h1, "R10", "irq status tx bit");
    bus_write(5'h0C, 32'h1);
    check(irq_tx === 1'b0, "R10", "tx irq cleared", {31'h0, irq_tx}, 0);
    expect_reg(5'h0C, 32'h0, "R10", "irq status after clear");
    drain_tx();

    // R12: enables off, events leave flags clear; R6 receive and read
    bus_write(5'h08, 32'h3);
    send_byte(8'hE7);
    rx_frame(8'h12);
    drain_tx();
    expect_reg(5'h0C, 32'h0, "R12", "no flags with enables clear");
    check(irq_any === 1'b0, "R12", "irq_any low", {31'h0, irq_any}, 0);
    expect_reg(5'h04, 32'h2, "R6", "rx full set");
    expect_reg(5'h00, 32'h12, "R6", "received byte 0x12");
    expect_reg(5'h04, 32'h0, "R6", "rx full cleared by read");

    // R6 at a non-power-of-two divider, both directions
    bus_write(5'h10, 32'd20);
    cur_div = 20;
    send_byte(8'h96);
    rx_frame(8'hC3);
    expect_reg(5'h00, 32'hC3, "R6", "received byte 0xC3 at divider 20");
    drain_tx();

    // R8: overwrite of an uncollected byte
    rx_frame(8'h11);
    rx_frame(8'hEE);
    expect_reg(5'h04, 32'h2, "R8", "rx full after two frames");
    expect_reg(5'h00, 32'hEE, "R8", "newer byte kept");

    // R7: short start pulse discarded
    @(negedge clk);
    rxd = 1'b0;
    repeat (3) @(negedge clk);
    rxd = 1'b1;
    repeat (cur_div * 12) @(negedge clk);
    expect_reg(5'h04, 32'h0, "R7", "glitch delivers no byte");

    // R9: receiver disabled
    bus_write(5'h08, 32'h1);
    rx_frame(8'h77);
    expect_reg(5'h04, 32'h0, "R9", "no byte while rx disabled");

    // R11: both flags and the combined clear
    bus_write(5'h08, 32'hF);
    send_byte(8'h24);
    rx_frame(8'h42);
    check(irq_rx === 1'b1 && irq_tx === 1'b1 && irq_any === 1'b1, "R11",
          "both irq outputs", {29'h0, irq_any, irq_tx, irq_rx}, 7);
    expect_reg(5'h0C, 32'h3, "R11", "irq status both bits");
    expect_reg(5'h00, 32'h42, "R11", "byte behind rx irq");
    bus_write(5'h0C, 32'h3);
    check(irq_any === 1'b0, "R11", "combined irq cleared", {31'h0, irq_any}, 0);
    expect_reg(5'h0C, 32'h0, "R11", "irq status after combined clear");
    drain_tx();

    check(exp_q.size() == 0, "R4", "all queued bytes transmitted", exp_q.size(), 0);
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
    end
  end
endmodule